// File: doc/BRIEF.md
# Pulse Tone Channel with Frequency Sweep

This block produces a square-wave tone for a sound subsystem. An 11-bit period timer clocks a 16-step duty sequencer. The sequencer output gates a 4-bit level, which is either a fixed volume or a decaying envelope. A sweep unit can raise or lower the period on its own. A length counter turns the channel off after a programmed number of half-frame ticks. The envelope advances on quarter-frame pulses and the sweep and length counter on half-frame pulses. Both pulses come from an external frame sequencer.

Software configures the channel through four byte-wide registers selected by `wr_sel`:

- **Select 0 (control):** duty in bits 7:6, halt/loop in bit 5, constant-volume in bit 4, level/envelope period in bits 3:0.
- **Select 1 (sweep):** enable in bit 7, divider period in bits 6:4, direction in bit 3 (1 = decrease), shift in bits 2:0.
- **Select 2 (period low):** period bits 7:0.
- **Select 3 (period high):** period bits 10:8 in bits 2:0, length index in bits 7:3.

The parameter `ONES_NEG` picks how the decreasing sweep negates. When it is 1, the decreasing sweep adds the one's complement of the shifted period. When it is 0, it subtracts the shifted period exactly.

Top module: `pulse_tone_channel`

## Requirements
- R1: After a synchronous reset, `amp_out` is 0 and `active` is 0.
- R2: A write to select 3 while `ch_enable` is high loads the length counter with index*4+2, where the index is bits 7:3 of the write. Each `half_tick` decrements the counter by one unless the halt bit (control bit 5) is set. `active` is high exactly while the counter is nonzero.
- R3: `ch_enable` low clears the length counter on the next clock. A select-3 write made while `ch_enable` is low loads nothing.
- R4: The duty step advances once every period+1 clocks and wraps after 16 steps. A select-3 write resets the step to 0. The output is high on steps below 2, 4, 8 or 12 for duty codes 0 to 3.
- R5: With constant-volume set (control bit 4), a high step outputs control bits 3:0.
- R6: A select-3 write sets the envelope to 15. With envelope period p, the envelope decrements once per p+1 quarter ticks. At 0 it stays at 0, or reloads 15 when the loop bit (control bit 5) is set. In envelope mode a high step outputs the envelope value.
- R7: The sweep divider reloads from bits 6:4 on a select-1 write and on expiry. On each expiry with sweep enabled, a nonzero shift and the channel not muted, the period becomes the sweep target. With direction 0 the target is period + (period >> shift).
- R8: With direction 1 the target is period − (period >> shift) − 1 when `ONES_NEG` = 1, and period − (period >> shift) when `ONES_NEG` = 0.
- R9: The output is 0 while the period is below 8.
- R10: With direction 0 the output is 0 while the period exceeds the limit for the current shift. The limits for shifts 0 to 7 are 0x3FF, 0x555, 0x666, 0x71C, 0x787, 0x7C1, 0x7E0 and 0x7F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one clock per write |
| wr_sel | input | 2 | Register select 0..3 |
| wr_data | input | 8 | Write data byte |
| ch_enable | input | 1 | Channel enable; low clears the length counter |
| qtr_tick | input | 1 | Quarter-frame pulse, clocks the envelope |
| half_tick | input | 1 | Half-frame pulse, clocks sweep and length counter |
| amp_out | output | 4 | Current output amplitude |
| active | output | 1 | High while the length counter is nonzero |

## Verification
The properties assume that `qtr_tick`, `half_tick` and `wr_en` are one-clock pulses and that reset is released on a clock edge. They also assume that the step and envelope dividers only move when their own strobes or counters allow it. The stimulus drives every input on the falling edge and raises each strobe for exactly one rising edge. It samples outputs shortly after a falling edge, so every expected value refers to a whole number of rising edges after the write or tick that caused it. Periods are chosen long enough that each level check lands on a high duty step.

// File: rtl/pulse_pkg.sv
// pulse_pkg: shared widths, register field layouts and small lookup functions
// for the pulse tone channel. Assumes 8-bit register writes.
package pulse_pkg;

    localparam int PER_W  = 11;  // period timer width
    localparam int STEP_W = 4;   // 16-step duty sequence
    localparam int LVL_W  = 4;   // amplitude / envelope width
    localparam int LEN_W  = 8;   // length counter width

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SWEEP = 2'd1,
        SEL_PLO   = 2'd2,
        SEL_PHI   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]       duty;
        logic             halt_loop;
        logic             fixed_lvl;
        logic [LVL_W-1:0] level;
    } ctrl_t;

    typedef struct packed {
        logic       on;
        logic [2:0] per;
        logic       down;
        logic [2:0] shift;
    } sweep_cfg_t;

    // Highest period allowed while sweeping upward, per shift amount.
    function automatic logic [PER_W-1:0] up_limit(input logic [2:0] sh);
        case (sh)
            3'd0:    up_limit = 11'h3FF;
            3'd1:    up_limit = 11'h555;
            3'd2:    up_limit = 11'h666;
            3'd3:    up_limit = 11'h71C;
            3'd4:    up_limit = 11'h787;
            3'd5:    up_limit = 11'h7C1;
            3'd6:    up_limit = 11'h7E0;
            default: up_limit = 11'h7F0;
        endcase
    endfunction

    // Number of leading high steps in the 16-step sequence.
    function automatic logic [STEP_W-1:0] high_steps(input logic [1:0] d);
        case (d)
            2'd0:    high_steps = 4'd2;
            2'd1:    high_steps = 4'd4;
            2'd2:    high_steps = 4'd8;
            default: high_steps = 4'd12;
        endcase
    endfunction

    // Length counter load value: index*4 + 2.
    function automatic logic [LEN_W-1:0] len_value(input logic [4:0] idx);
        len_value = {1'b0, idx, 2'b10};
    endfunction

endpackage

// File: rtl/pulse_timer_seq.sv
// pulse_timer_seq: down-counting period timer that advances a 16-step duty
// sequencer once every period+1 clocks. A restart puts the sequencer on step 0
// and loads the timer with the period being written in the same cycle.
module pulse_timer_seq
    import pulse_pkg::*;
#(
    parameter int P_W = PER_W,
    parameter int S_W = STEP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [P_W-1:0] period,
    input  logic           restart,
    input  logic [P_W-1:0] restart_per,
    output logic [S_W-1:0] step
);
    localparam logic [P_W-1:0] P_ONE = 1;
    localparam logic [S_W-1:0] S_ONE = 1;

    logic [P_W-1:0] tmr;

    // Timer countdown and sequencer advance on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr  <= '0;
            step <= '0;
        end else if (restart) begin
            tmr  <= restart_per;
            step <= '0;
        end else if (tmr == '0) begin
            tmr  <= period;
            step <= step + S_ONE;
        end else begin
            tmr <= tmr - P_ONE;
        end
    end

    // R4: the step may only move when the timer expires or on a restart.
    a_r4_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && tmr != '0) |=> $stable(step))
        else $error("a_r4_step_hold");

endmodule

// File: rtl/pulse_envelope.sv
// pulse_envelope: 4-bit decaying level clocked by quarter-frame pulses through
// a divider of (period+1) pulses. Restart sets full level; loop makes 0 wrap
// back to full. Assumes qtr_tick is a single-clock pulse.
module pulse_envelope
    import pulse_pkg::*;
#(
    parameter int L_W = LVL_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic           qtr_tick,
    input  logic [L_W-1:0] env_per,
    input  logic           loop_en,
    output logic [L_W-1:0] level
);
    localparam logic [L_W-1:0] L_ONE = 1;

    logic [L_W-1:0] div;

    // Divider and level update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div   <= '0;
            level <= '0;
        end else if (restart) begin
            div   <= env_per;
            level <= '1;
        end else if (qtr_tick) begin
            if (div == '0) begin
                div <= env_per;
                if (level != '0)
                    level <= level - L_ONE;
                else if (loop_en)
                    level <= '1;
            end else begin
                div <= div - L_ONE;
            end
        end
    end

    // R6: without loop, an exhausted envelope stays at zero.
    a_r6_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (qtr_tick && !restart && div == '0 && level == '0 && !loop_en) |=> level == '0)
        else $error("a_r6_hold_at_zero");

endmodule

// File: rtl/pulse_sweep.sv
// pulse_sweep: owns the sweep configuration and the 11-bit period. Computes the
// sweep target, the mute condition, and applies the target on divider expiry.
// ONES_NEG picks one's- or two's-complement negation for downward sweeps.
module pulse_sweep
    import pulse_pkg::*;
#(
    parameter int P_W      = PER_W,
    parameter bit ONES_NEG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_wr,
    input  logic [7:0]     cfg_data,
    input  logic           lo_wr,
    input  logic [7:0]     lo_data,
    input  logic           hi_wr,
    input  logic [2:0]     hi_data,
    input  logic           half_tick,
    output logic [P_W-1:0] period,
    output logic           mute
);
    localparam logic [2:0] D_ONE = 3'd1;

    sweep_cfg_t     cfg;
    logic [2:0]     div;
    logic [P_W-1:0] shifted;
    logic [P_W-1:0] neg_term;
    logic [P_W-1:0] target;
    logic           expire;

    assign shifted = period >> cfg.shift;

    // Negation style chosen per instance.
    generate
        if (ONES_NEG) begin : g_ones
            assign neg_term = ~shifted;
        end else begin : g_twos
            assign neg_term = -shifted;
        end
    endgenerate

    // Target period and silence condition.
    always_comb begin
        target = cfg.down ? (period + neg_term) : (period + shifted);
        mute   = (period < 11'd8) || (!cfg.down && period > up_limit(cfg.shift));
        expire = half_tick && (div == '0);
    end

    // Configuration register and sweep divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            div <= '0;
        end else if (cfg_wr) begin
            cfg <= sweep_cfg_t'(cfg_data);
            div <= cfg_data[6:4];
        end else if (half_tick) begin
            div <= (div == '0) ? cfg.per : div - D_ONE;
        end
    end

    // Period register: software writes win over sweep updates.
    always_ff @(posedge clk) begin
        if (!rst_n)
            period <= '0;
        else if (lo_wr)
            period[7:0] <= lo_data;
        else if (hi_wr)
            period[P_W-1:8] <= hi_data;
        else if (expire && cfg.on && cfg.shift != '0 && !mute)
            period <= target;
    end

    // R7: the period only changes on a write or a half-frame tick.
    a_r7_period_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_wr && !hi_wr && !half_tick) |=> $stable(period))
        else $error("a_r7_period_stable");

endmodule

// File: rtl/pulse_length.sv
// pulse_length: note length counter. Loads on a period-high write while the
// channel is enabled, counts down on half-frame pulses unless halted, and is
// forced to zero while the channel is disabled.
module pulse_length
    import pulse_pkg::*;
#(
    parameter int N_W = LEN_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ch_enable,
    input  logic           load,
    input  logic [N_W-1:0] load_val,
    input  logic           half_tick,
    input  logic           halt,
    output logic           nonzero
);
    localparam logic [N_W-1:0] N_ONE = 1;

    logic [N_W-1:0] cnt;

    // Counter load, clear and countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!ch_enable)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (half_tick && !halt && cnt != '0)
            cnt <= cnt - N_ONE;
    end

    assign nonzero = (cnt != '0);

    // R3: a disabled channel is inactive on the following clock.
    a_r3_cleared_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enable |=> !nonzero)
        else $error("a_r3_cleared_when_disabled");

endmodule

// File: rtl/pulse_tone_channel.sv
// pulse_tone_channel: square-wave channel top. Decodes the four register
// writes, holds the control register, and combines sequencer, envelope, sweep
// mute and length state into the 4-bit amplitude. Assumes one write per clock
// and single-clock frame pulses from an external frame sequencer.
module pulse_tone_channel
    import pulse_pkg::*;
#(
    parameter bit ONES_NEG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             ch_enable,
    input  logic             qtr_tick,
    input  logic             half_tick,
    output logic [LVL_W-1:0] amp_out,
    output logic             active
);
    ctrl_t             ctrl;
    logic              wr_ctrl, wr_sweep, wr_lo, wr_hi;
    logic [PER_W-1:0]  period;
    logic              mute;
    logic [STEP_W-1:0] step;
    logic [LVL_W-1:0]  env_level;
    logic              high;

    // Register write decode.
    always_comb begin
        wr_ctrl  = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
        wr_sweep = wr_en && (reg_sel_e'(wr_sel) == SEL_SWEEP);
        wr_lo    = wr_en && (reg_sel_e'(wr_sel) == SEL_PLO);
        wr_hi    = wr_en && (reg_sel_e'(wr_sel) == SEL_PHI);
    end

    // Control register: duty, halt/loop, fixed level, level/envelope period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_ctrl)
            ctrl <= ctrl_t'(wr_data);
    end

    pulse_sweep #(.P_W(PER_W), .ONES_NEG(ONES_NEG)) u_sweep (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_sweep),
        .cfg_data  (wr_data),
        .lo_wr     (wr_lo),
        .lo_data   (wr_data),
        .hi_wr     (wr_hi),
        .hi_data   (wr_data[2:0]),
        .half_tick (half_tick),
        .period    (period),
        .mute      (mute)
    );

    pulse_timer_seq #(.P_W(PER_W), .S_W(STEP_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .period      (period),
        .restart     (wr_hi),
        .restart_per ({wr_data[2:0], period[7:0]}),
        .step        (step)
    );

    pulse_envelope #(.L_W(LVL_W)) u_env (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_hi),
        .qtr_tick (qtr_tick),
        .env_per  (ctrl.level),
        .loop_en  (ctrl.halt_loop),
        .level    (env_level)
    );

    pulse_length #(.N_W(LEN_W)) u_len (
        .clk       (clk),
        .rst_n     (rst_n),
        .ch_enable (ch_enable),
        .load      (wr_hi),
        .load_val  (len_value(wr_data[7:3])),
        .half_tick (half_tick),
        .halt      (ctrl.halt_loop),
        .nonzero   (active)
    );

    // Output amplitude selection.
    always_comb begin
        high    = step < high_steps(ctrl.duty);
        amp_out = '0;
        if (active && !mute && high)
            amp_out = ctrl.fixed_lvl ? ctrl.level : env_level;
    end

    // R2: an enabled period-high write always leaves the channel active.
    a_r2_load_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && ch_enable) |=> active)
        else $error("a_r2_load_on_write");

endmodule

// File: tb/test_pulse_tone_channel.sv
// Scoreboard bench: driver tasks push expected output values into a queue;
// a monitor pops and compares them shortly after each falling edge.
module test_pulse_tone_channel;
    import pulse_pkg::*;

    localparam bit ONES = 1'b1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [1:0] wr_sel;
    logic [7:0] wr_data;
    logic       ch_enable;
    logic       qtr_tick;
    logic       half_tick;
    logic [3:0] amp_out;
    logic       active;

    always #10 clk = ~clk;  // 50 MHz

    pulse_tone_channel #(.ONES_NEG(ONES)) i_pulse_tone_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .ch_enable (ch_enable),
        .qtr_tick  (qtr_tick),
        .half_tick (half_tick),
        .amp_out   (amp_out),
        .active    (active)
    );

    typedef struct {
        string req;
        bit    is_active;
        int    val;
    } exp_t;

    exp_t sbq[$];
    exp_t cur;
    int   checks = 0;
    int   errors = 0;
    int   got;
    bit   done = 1'b0;

    // Monitor: compare queued expectations against the outputs.
    always @(negedge clk) begin
        #2;
        while (sbq.size() > 0) begin
            cur = sbq.pop_front();
            got = cur.is_active ? int'(active) : int'(amp_out);
            checks++;
            if (got != cur.val) begin
                errors++;
                $display("FAIL %s %s: actual %0d expected %0d", cur.req,
                         cur.is_active ? "active" : "amp_out", got, cur.val);
            end
        end
    end

    task automatic expect_amp(input string req, input int v);
        sbq.push_back('{req, 1'b0, v});
    endtask

    task automatic expect_act(input string req, input int v);
        sbq.push_back('{req, 1'b1, v});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic qtr(input int n);
        repeat (n) begin
            @(negedge clk); qtr_tick = 1'b1;
            @(negedge clk); qtr_tick = 1'b0;
        end
    endtask

    task automatic half(input int n);
        repeat (n) begin
            @(negedge clk); half_tick = 1'b1;
            @(negedge clk); half_tick = 1'b0;
        end
    endtask

    task automatic set_en(input logic v);
        @(negedge clk); ch_enable = v;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        ch_enable = 1'b0; qtr_tick = 1'b0; half_tick = 1'b0;
        idle(3);
        // R1: reset state
        expect_amp("R1", 0);
        expect_act("R1", 0);
        rst_n = 1'b1; ch_enable = 1'b1;

        // R4 / R5: duty 1, fixed level 9, period 9 -> 10 clocks per step
        wr(2'd0, 8'h59);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd9);
        wr(2'd3, 8'h28);                 // index 5 -> length 22
        expect_amp("R5", 9);
        expect_act("R2", 1);
        idle(39); expect_amp("R4", 9);   // step 3
        idle(1);  expect_amp("R4", 0);   // step 4
        idle(120); expect_amp("R4", 9);  // step 16 wraps to 0

        // R4: duty 3, restart resets the step
        wr(2'd0, 8'hD9);
        wr(2'd3, 8'h28);
        idle(119); expect_amp("R4", 9);  // step 11
        idle(1);   expect_amp("R4", 0);  // step 12

        // R2: length index 0 -> two half ticks
        wr(2'd0, 8'hDF);
        wr(2'd3, 8'h00);
        expect_act("R2", 1); expect_amp("R5", 15);
        half(1); expect_act("R2", 1);
        half(1); expect_act("R2", 0); expect_amp("R2", 0);

        // R2: halt bit freezes the counter
        wr(2'd0, 8'hFF);
        wr(2'd3, 8'h00);
        half(3); expect_act("R2", 1);

        // R3: disable clears, disabled write loads nothing
        set_en(1'b0); expect_act("R3", 0); expect_amp("R3", 0);
        wr(2'd3, 8'h00); expect_act("R3", 0);
        set_en(1'b1); expect_act("R3", 0);
        wr(2'd3, 8'h00); expect_act("R3", 1);

        // R6: envelope period 1, long tone period 0x3FF
        wr(2'd0, 8'hC1);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFB);
        expect_amp("R6", 15);
        qtr(1);  expect_amp("R6", 15);
        qtr(1);  expect_amp("R6", 14);
        qtr(28); expect_amp("R6", 0);
        qtr(2);  expect_amp("R6", 0);    // no loop: stays
        wr(2'd0, 8'hE1);
        qtr(2);  expect_amp("R6", 15);   // loop: wraps

        // R10: upward limit for shift 0
        wr(2'd0, 8'hDF);
        wr(2'd1, 8'h80);
        wr(2'd3, 8'hFB);
        expect_amp("R10", 15);           // 0x3FF allowed
        wr(2'd2, 8'h00);
        wr(2'd3, 8'hFC);
        expect_amp("R10", 0);            // 0x400 above limit

        // R7: shift 1, divider period 1, 0x400 -> 0x600 (above 0x555)
        wr(2'd1, 8'h91);
        expect_amp("R10", 15);
        half(1); expect_amp("R7", 15);
        half(1); expect_amp("R7", 0);

        // R8: downward shift 3 from period 9
        wr(2'd1, 8'h8B);
        wr(2'd2, 8'd9);
        wr(2'd3, 8'hF8);
        expect_amp("R8", 15);
        half(1); expect_amp("R8", ONES ? 0 : 15);  // 7 vs 8

        // R9: small periods are silent
        wr(2'd1, 8'h00);
        wr(2'd2, 8'd7);
        wr(2'd3, 8'hF8);
        expect_amp("R9", 0);
        wr(2'd2, 8'd8);
        expect_amp("R9", 15);

        idle(4);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule